// File: doc/BRIEF.md
# DRAM Row/Column Address Multiplexer

This block turns a 21-bit byte address into the 10-bit row address and the 10-bit column address that one DRAM bank needs. Address bit 0 is never used because the data path is 16 bits wide. The remaining 20 word-address bits are split into a row and a column. The split follows one of two mapping styles. The contiguous style puts the lower word-address bits in the row and the upper ones in the column. The interleaved style alternates between row and column, starting with the row.

A bank-size input selects 128 kB, 512 kB or 2 MB. At the two smaller sizes the upper row and column lines do not exist, and the two styles handle this differently. The contiguous style repacks the word address so that the column starts directly above the shortened row. The interleaved style keeps every bit where it was and forces the missing upper lines to zero. A phase input chooses whether the row or the column goes onto a shared, registered address output for the DRAM pins. Strobe and refresh timing are generated elsewhere.

Top module: `dram_addr_mux`

## Requirements
- R1: With map_style=0 (contiguous) and bank_size=2'b10 (2 MB), row_addr[i]=byte_addr[i+1] and col_addr[i]=byte_addr[i+11] for i=0..9.
- R2: With map_style=0 and bank_size=2'b01 (512 kB), row_addr[8:0]=byte_addr[9:1], col_addr[8:0]=byte_addr[18:10], and bit 9 of both is 0.
- R3: With map_style=0 and bank_size=2'b00 (128 kB), row_addr[7:0]=byte_addr[8:1], col_addr[7:0]=byte_addr[16:9], and bits 9:8 of both are 0.
- R4: With map_style=1 (interleaved) and bank_size=2'b10, row_addr[i]=byte_addr[2i+1] and col_addr[i]=byte_addr[2i+2] for i=0..9.
- R5: With map_style=1 and a smaller bank, the bit positions of R4 are kept: at 512 kB bit 9 of row and column is 0, and at 128 kB bits 9:8 of both are 0.
- R6: byte_addr[0] never affects any output, and neither do address bits above the bank's range (for a contiguous 512 kB bank, byte_addr[20:19]).
- R7: bank_size=2'b11 maps exactly like 2'b10 (2 MB).
- R8: At each rising clk edge, dram_addr takes row_addr when col_phase=0 and col_addr when col_phase=1, as both stand before that edge.
- R9: While rst_n is low, dram_addr is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_addr | input | 21 | Byte address within the bank |
| map_style | input | 1 | 0 = contiguous, 1 = interleaved |
| bank_size | input | 2 | 00 = 128 kB, 01 = 512 kB, 10 or 11 = 2 MB |
| col_phase | input | 1 | 0 = row onto dram_addr, 1 = column |
| row_addr | output | 10 | Row address (combinational) |
| col_addr | output | 10 | Column address (combinational) |
| dram_addr | output | 10 | Registered multiplexed address for the DRAM pins |

## Verification
The mapping is tried with a few kinds of address. Single bits at the positions where a small bank wraps (0x208, 0x408, 0x40008, 0x80008) show which output line each address line reaches in every style and size. All-ones addresses show how many upper lines a size clears. Alternating-bit patterns separate the interleaved row bits from the column bits. An irregular value catches swapped or shifted slices. Addresses with only bit 0 set, or only bits above the bank's range set, show that those bits are dropped. Directed clocked tests check that the phase input selects between row and column, and that reset clears the registered output.

// File: rtl/dam_pkg.sv
package dam_pkg;

  typedef enum logic [1:0] {
    SZ_128K = 2'b00,
    SZ_512K = 2'b01,
    SZ_2M   = 2'b10,
    SZ_2M_B = 2'b11
  } bank_size_e;

  // Number of row/column lines that a bank size lacks, counted from the top.
  function automatic int unsigned dropped_lines(input logic [1:0] sz);
    case (sz)
      SZ_128K: dropped_lines = 2;
      SZ_512K: dropped_lines = 1;
      default: dropped_lines = 0;
    endcase
  endfunction

endpackage

// File: rtl/dam_contig_map.sv
module dam_contig_map #(
  parameter int ROW_W = 10,
  localparam int WA_W = 2 * ROW_W,
  localparam int KW   = $clog2(ROW_W + 1)
) (
  input  logic [WA_W-1:0]  word_addr,
  input  logic [KW-1:0]    keep,
  output logic [ROW_W-1:0] row,
  output logic [ROW_W-1:0] col
);
  // The row takes the lowest 'keep' word bits and the column the next 'keep'.
  always_comb begin
    row = '0;
    col = '0;
    for (int i = 0; i < ROW_W; i++) begin
      if (i < int'(keep)) begin
        row[i] = word_addr[i];
        col[i] = word_addr[i + int'(keep)];
      end
    end
  end
endmodule

// File: rtl/dam_ilv_map.sv
module dam_ilv_map #(
  parameter int ROW_W = 10,
  localparam int WA_W = 2 * ROW_W,
  localparam int KW   = $clog2(ROW_W + 1)
) (
  input  logic [WA_W-1:0]  word_addr,
  input  logic [KW-1:0]    keep,
  output logic [ROW_W-1:0] row,
  output logic [ROW_W-1:0] col
);
  // The even word bits go to the row and the odd ones to the column; lines at or above 'keep' are held at 0.
  for (genvar i = 0; i < ROW_W; i++) begin : g_bit
    logic present;
    assign present = (KW'(i) < keep);
    assign row[i]  = present & word_addr[2*i];
    assign col[i]  = present & word_addr[2*i + 1];
  end
endmodule

// File: rtl/dam_addr_reg.sv
module dam_addr_reg #(
  parameter int ROW_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_col,
  input  logic [ROW_W-1:0] row,
  input  logic [ROW_W-1:0] col,
  output logic [ROW_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= sel_col ? col : row;
  end
endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux #(
  parameter int ROW_W = 10,
  localparam int ADDR_W = 2 * ROW_W + 1,
  localparam int KW     = $clog2(ROW_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] byte_addr,
  input  logic              map_style,
  input  logic [1:0]        bank_size,
  input  logic              col_phase,
  output logic [ROW_W-1:0]  row_addr,
  output logic [ROW_W-1:0]  col_addr,
  output logic [ROW_W-1:0]  dram_addr
);
  import dam_pkg::*;

  logic              unused_byte_lsb;
  logic [KW-1:0]     keep_lines;
  logic [ROW_W-1:0]  contig_row, contig_col, ilv_row, ilv_col;

  assign unused_byte_lsb = byte_addr[0];
  assign keep_lines = KW'(ROW_W - int'(dropped_lines(bank_size)));

  dam_contig_map #(.ROW_W(ROW_W)) u_contig (
    .word_addr (byte_addr[ADDR_W-1:1]),
    .keep      (keep_lines),
    .row       (contig_row),
    .col       (contig_col)
  );

  dam_ilv_map #(.ROW_W(ROW_W)) u_ilv (
    .word_addr (byte_addr[ADDR_W-1:1]),
    .keep      (keep_lines),
    .row       (ilv_row),
    .col       (ilv_col)
  );

  assign row_addr = map_style ? ilv_row : contig_row;
  assign col_addr = map_style ? ilv_col : contig_col;

  dam_addr_reg #(.ROW_W(ROW_W)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_col (col_phase),
    .row     (row_addr),
    .col     (col_addr),
    .q       (dram_addr)
  );
endmodule

// File: rtl/dam_checker.sv
module dam_checker #(
  parameter int ROW_W = 10,
  localparam int ADDR_W = 2 * ROW_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] byte_addr,
  input logic              map_style,
  input logic [1:0]        bank_size,
  input logic              col_phase,
  input logic [ROW_W-1:0]  row_addr,
  input logic [ROW_W-1:0]  col_addr,
  input logic [ROW_W-1:0]  dram_addr
);
  AST_CONTIG_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (!map_style && bank_size[1]) |-> (row_addr[0] == byte_addr[1] && col_addr[0] == byte_addr[ROW_W+1])); // R1
  AST_CONTIG_MID: assert property (@(posedge clk) disable iff (!rst_n)
    (!map_style && bank_size == 2'b01) |-> (col_addr[0] == byte_addr[ROW_W] && !row_addr[ROW_W-1])); // R2
  AST_SMALL_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_size == 2'b00) |-> ($countones({row_addr[ROW_W-1 -: 2], col_addr[ROW_W-1 -: 2]}) == 0)); // R3
  AST_ILV_LSB: assert property (@(posedge clk) disable iff (!rst_n)
    map_style |-> (row_addr[0] == byte_addr[1] && col_addr[0] == byte_addr[2])); // R4
  AST_ILV_MID_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (map_style && bank_size == 2'b01) |-> (!row_addr[ROW_W-1] && !col_addr[ROW_W-1])); // R5
  AST_MUX_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(col_phase)) |-> (dram_addr == $past(row_addr))); // R8
  AST_MUX_COL: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(col_phase)) |-> (dram_addr == $past(col_addr))); // R8
  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |-> (dram_addr == '0)); // R9
endmodule

bind dram_addr_mux dam_checker #(.ROW_W(ROW_W)) u_dam_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .byte_addr (byte_addr),
  .map_style (map_style),
  .bank_size (bank_size),
  .col_phase (col_phase),
  .row_addr  (row_addr),
  .col_addr  (col_addr),
  .dram_addr (dram_addr)
);

// File: tb/tb_dram_addr_mux.sv
`timescale 1ns/1ps
module tb_dram_addr_mux;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [20:0] byte_addr = '0;
  logic        map_style = 1'b0;
  logic [1:0]  bank_size = 2'b10;
  logic        col_phase = 1'b0;
  logic [9:0]  row_addr, col_addr, dram_addr;
  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  dram_addr_mux dut (
    .clk(clk), .rst_n(rst_n), .byte_addr(byte_addr), .map_style(map_style),
    .bank_size(bank_size), .col_phase(col_phase),
    .row_addr(row_addr), .col_addr(col_addr), .dram_addr(dram_addr)
  );

  // {addr[20:0], style, size[1:0], row[9:0], col[9:0]}
  localparam int NV = 17;
  localparam logic [43:0] VEC [NV] = '{
    {21'h000408, 1'b0, 2'b10, 10'h204, 10'h000},  // R1
    {21'h000408, 1'b0, 2'b01, 10'h004, 10'h001},  // R2
    {21'h000208, 1'b0, 2'b00, 10'h004, 10'h001},  // R3
    {21'h080008, 1'b1, 2'b10, 10'h202, 10'h000},  // R4
    {21'h080008, 1'b1, 2'b01, 10'h002, 10'h000},  // R5
    {21'h040008, 1'b1, 2'b10, 10'h002, 10'h100},  // R4
    {21'h040008, 1'b1, 2'b00, 10'h002, 10'h000},  // R5
    {21'h1FFFFF, 1'b0, 2'b10, 10'h3FF, 10'h3FF},  // R1
    {21'h1FFFFF, 1'b0, 2'b01, 10'h1FF, 10'h1FF},  // R2
    {21'h1FFFFF, 1'b1, 2'b00, 10'h0FF, 10'h0FF},  // R5
    {21'h1FFFFF, 1'b1, 2'b01, 10'h1FF, 10'h1FF},  // R5
    {21'h1FFFFF, 1'b0, 2'b11, 10'h3FF, 10'h3FF},  // R7
    {21'h000001, 1'b0, 2'b10, 10'h000, 10'h000},  // R6
    {21'h180000, 1'b0, 2'b01, 10'h000, 10'h000},  // R6
    {21'h0AAAAA, 1'b1, 2'b10, 10'h3FF, 10'h000},  // R4
    {21'h155554, 1'b1, 2'b10, 10'h000, 10'h3FF},  // R4
    {21'h012345, 1'b0, 2'b10, 10'h1A2, 10'h024}   // R1
  };

  task automatic check(input string req, input string what, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R9: the output is cleared while reset is held, even with the clock running
    byte_addr = 21'h1FFFFF; col_phase = 1'b1;
    repeat (3) @(posedge clk);
    #1 check("R9", "dram_addr in reset", dram_addr, 10'h000);
    @(negedge clk) rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      {byte_addr, map_style, bank_size} = VEC[k][43:20];
      #1;
      check("R1-7 table", $sformatf("row vec %0d", k), row_addr, VEC[k][19:10]);
      check("R1-7 table", $sformatf("col vec %0d", k), col_addr, VEC[k][9:0]);
    end

    // R8: phase picks the row or the column at the next rising edge
    @(negedge clk);
    byte_addr = 21'h012345; map_style = 1'b0; bank_size = 2'b10; col_phase = 1'b0;
    @(posedge clk); #1 check("R8", "row phase", dram_addr, 10'h1A2);
    @(negedge clk) col_phase = 1'b1;
    @(posedge clk); #1 check("R8", "col phase", dram_addr, 10'h024);
    // R8: the column in interleaved style at 128 kB
    @(negedge clk); byte_addr = 21'h1FFFFF; map_style = 1'b1; bank_size = 2'b00;
    @(posedge clk); #1 check("R8", "col phase ilv 128k", dram_addr, 10'h0FF);
    @(negedge clk) col_phase = 1'b0;
    @(posedge clk); #1 check("R8", "row phase ilv 128k", dram_addr, 10'h0FF);
    // R6: bit 0 changes nothing in interleaved style
    @(negedge clk); byte_addr = 21'h000001; bank_size = 2'b10; #1;
    check("R6", "row A0 only ilv", row_addr, 10'h000);
    check("R6", "col A0 only ilv", col_addr, 10'h000);
    // R3: the column bit above the 128 kB range is dropped in contiguous style
    @(negedge clk); byte_addr = 21'h020000; map_style = 1'b0; bank_size = 2'b00; #1;
    check("R3", "col A17 at 128k", col_addr, 10'h000);
    // R9: an asynchronous reset in mid-run clears the output
    @(posedge clk); #1;
    @(negedge clk) rst_n = 1'b0;
    #1 check("R9", "async clear", dram_addr, 10'h000);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule